// File: doc/BRIEF.md
# On-Demand DMA Request Handshake Controller

This block sits on the host side of a 32-bit data bus that the host shares with an external requester. The requester asks for the bus with a release request. The controller answers with a one-cycle bus-available pulse. A fixed number of cycles later it drops its data-bus output enable for exactly one cycle. In that cycle the requester drives a transfer-request word and raises a transfer-request strobe. The controller samples the word and turns its low bits into a channel request for a DMA engine that sits downstream.

There are two more request forms, and neither needs the bus. A strobe that arrives outside the release cycle repeats a request to the channel that was requested most recently. A strobe that arrives together with a release request is a direct request, and it always goes to channel 2. The three forms are told apart only by which strobes are high and where they fall relative to the grant. Every accepted request produces a one-cycle pulse on one of four channel-request lines. The most recently captured word is presented alongside that pulse.

Top module: `odt_req_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `bus_grant_o` is 0, `bus_oe_o` is 1, `chan_req_o` is 0 and `req_word_o` is 0.
- R2: When the controller is idle and samples `bus_rel_req_i`=1 with `xfer_stb_i`=0, `bus_grant_o` is 1 for exactly the next cycle.
- R3: `bus_oe_o` is 0 in exactly one cycle, the one that comes 2 cycles after the `bus_grant_o` cycle (the release cycle). It is 1 again in the cycle after that.
- R4: If `xfer_stb_i`=1 in the release cycle, the word on `bus_data_i` is captured. In the next cycle `chan_req_o` has only bit `bus_data_i[1:0]` set and `req_word_o` equals the captured word. `req_word_o` keeps that value until the next capture.
- R5: A release cycle with `xfer_stb_i`=0 produces no channel pulse and leaves `req_word_o` unchanged.
- R6: `xfer_stb_i`=1 with `bus_rel_req_i`=0 outside the release cycle is a repeat request. In the next cycle `chan_req_o` pulses the channel requested most recently, and `req_word_o` is unchanged.
- R7: A repeat request made before any format or direct request has been accepted since reset produces no pulse.
- R8: `bus_rel_req_i`=1 and `xfer_stb_i`=1 in the same cycle outside the release cycle is a direct request. In the next cycle only `chan_req_o[2]` is set and no grant follows. Channel 2 becomes the remembered channel.
- R9: A release request seen while a grant sequence is running (the grant cycle up to and including the release cycle) is ignored and starts no grant. Once the sequence is back at idle, a new request is accepted.
- R10: `chan_req_o` never has more than one bit set. A pulse occurs only in the cycle after an accepted request, so with no request the output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rel_req_i | input | 1 | Requester asks for the data bus to be released |
| xfer_stb_i | input | 1 | Transfer-request strobe from the requester |
| bus_data_i | input | 32 | Value seen on the shared data lines |
| bus_grant_o | output | 1 | One-cycle bus-available pulse |
| bus_oe_o | output | 1 | Host data-bus output enable; 0 means the lines are released |
| chan_req_o | output | 4 | One-cycle request pulse, one bit per DMA channel |
| req_word_o | output | 32 | Most recently captured transfer-request word |

## Verification
The schedule runs as follows:
- The grant is due one cycle after an accepted release request.
- The release cycle falls two cycles after the grant, and the output enable returns one cycle after the release.
- A channel pulse and any new word appear one cycle after the cycle whose strobe produced them.

The bench drives inputs on the falling edge. It advances a behavioural model at each rising edge from the inputs it has just applied, and compares every output 2 ns after that edge. Every cycle is therefore checked against the value due in that cycle. Directed sequences cover requests that arrive during a running sequence, repeats before any channel is remembered, direct requests and a release cycle with no strobe. A long pseudo-random stretch then mixes all of these.

// File: rtl/odt_pkg.sv
`timescale 1ns/1ps
// Shared types for the on-demand request handshake controller.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package odt_pkg;

    // Kind of request decoded in the current cycle
    typedef enum logic [1:0] {
        REQ_NONE   = 2'd0,
        REQ_FORMAT = 2'd1,
        REQ_REPEAT = 2'd2,
        REQ_DIRECT = 2'd3
    } req_kind_e;

    // Phase of the bus grant sequence
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_HOLD = 2'd1,
        SEQ_CAPT = 2'd2
    } seq_state_e;

endpackage

// File: rtl/odt_bus_seq.sv
`timescale 1ns/1ps
// Grant sequencer: on start it emits a one-cycle grant. It then waits, and
// releases the data bus (output enable low) for one capture cycle exactly
// REL_DELAY cycles after the grant, then returns to idle.
// Assumes: REL_DELAY >= 1; start is only honoured while idle.
module odt_bus_seq
    import odt_pkg::*;
#(
    parameter int REL_DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic idle_o,
    output logic capt_o,
    output logic grant_o,
    output logic bus_oe_o
);
    localparam int CNT_W = (REL_DELAY > 1) ? $clog2(REL_DELAY) : 1;
    localparam logic [CNT_W-1:0] LAST_HOLD = CNT_W'(REL_DELAY - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    // Advance the grant / wait / capture sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start_i) begin
                        state_q <= SEQ_HOLD;
                        cnt_q   <= '0;
                    end
                end
                SEQ_HOLD: begin
                    if (cnt_q == LAST_HOLD) begin
                        state_q <= SEQ_CAPT;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SEQ_CAPT: state_q <= SEQ_IDLE;
                default:  state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Decode sequence phase into bus-side controls
    always_comb begin
        idle_o   = (state_q == SEQ_IDLE);
        capt_o   = (state_q == SEQ_CAPT);
        grant_o  = (state_q == SEQ_HOLD) && (cnt_q == '0);
        bus_oe_o = !capt_o;
    end

endmodule

// File: rtl/odt_req_decode.sv
`timescale 1ns/1ps
// Request classifier: tells the three request forms apart from the strobe
// combination and the sequence phase. In the capture cycle the strobe
// qualifies the bus word. Outside it, the strobe alone means a repeat, and
// the strobe plus a release request means a direct request.
// Assumes: inputs are synchronous to clk.
module odt_req_decode
    import odt_pkg::*;
(
    input  logic      idle_i,
    input  logic      capt_i,
    input  logic      rel_req_i,
    input  logic      stb_i,
    output req_kind_e kind_o,
    output logic      start_o
);
    // Classify the current cycle's strobes
    always_comb begin
        kind_o = REQ_NONE;
        if (capt_i) begin
            if (stb_i) kind_o = REQ_FORMAT;
        end else if (stb_i && rel_req_i) begin
            kind_o = REQ_DIRECT;
        end else if (stb_i) begin
            kind_o = REQ_REPEAT;
        end
    end

    // A new grant starts only from idle, for a request without a strobe
    always_comb begin
        start_o = idle_i && rel_req_i && !stb_i;
    end

endmodule

// File: rtl/odt_chan_out.sv
`timescale 1ns/1ps
// Channel output stage: picks the target channel for the decoded request and
// remembers the most recent one for repeats. It registers a one-hot pulse and
// keeps the last captured word.
// Assumes: NUM_CH is a power of two; the channel field is the low bits of the word.
module odt_chan_out
    import odt_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_CH    = 4,
    parameter int DIRECT_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  req_kind_e         kind_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [NUM_CH-1:0] chan_req_o,
    output logic [DATA_W-1:0] req_word_o
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [CH_W-1:0]   last_q;
    logic              last_v_q;
    logic [CH_W-1:0]   sel;
    logic              fire;
    logic              remember;
    logic [NUM_CH-1:0] onehot;
    logic [NUM_CH-1:0] pulse_q;
    logic [DATA_W-1:0] word_q;

    // Choose target channel and whether a pulse is due
    always_comb begin
        sel      = last_q;
        fire     = 1'b0;
        remember = 1'b0;
        unique case (kind_i)
            REQ_FORMAT: begin
                sel      = data_i[CH_W-1:0];
                fire     = 1'b1;
                remember = 1'b1;
            end
            REQ_DIRECT: begin
                sel      = CH_W'(DIRECT_CH);
                fire     = 1'b1;
                remember = 1'b1;
            end
            REQ_REPEAT: fire = last_v_q;
            default:    fire = 1'b0;
        endcase
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_onehot
        assign onehot[g] = fire && (sel == CH_W'(g));
    end

    // Register pulse, captured word and remembered channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q  <= '0;
            word_q   <= '0;
            last_q   <= '0;
            last_v_q <= 1'b0;
        end else begin
            pulse_q <= onehot;
            if (kind_i == REQ_FORMAT) word_q <= data_i;
            if (remember) begin
                last_q   <= sel;
                last_v_q <= 1'b1;
            end
        end
    end

    assign chan_req_o = pulse_q;
    assign req_word_o = word_q;

endmodule

// File: rtl/odt_req_ctrl.sv
`timescale 1ns/1ps
// On-demand DMA request handshake controller (top). It grants the shared
// data bus to an external requester, releases it for one capture cycle,
// and turns format, repeat and direct requests into channel pulses.
// Assumes: all inputs synchronous to clk; the data-bus tri-state buffer
// sits outside and is steered by bus_oe_o.
module odt_req_ctrl
    import odt_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_CH    = 4,
    parameter int DIRECT_CH = 2,
    parameter int REL_DELAY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rel_req_i,
    input  logic              xfer_stb_i,
    input  logic [DATA_W-1:0] bus_data_i,
    output logic              bus_grant_o,
    output logic              bus_oe_o,
    output logic [NUM_CH-1:0] chan_req_o,
    output logic [DATA_W-1:0] req_word_o
);
    logic      seq_idle;
    logic      seq_capt;
    logic      seq_start;
    req_kind_e kind;

    odt_bus_seq #(.REL_DELAY(REL_DELAY)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (seq_start),
        .idle_o   (seq_idle),
        .capt_o   (seq_capt),
        .grant_o  (bus_grant_o),
        .bus_oe_o (bus_oe_o)
    );

    odt_req_decode i_dec (
        .idle_i    (seq_idle),
        .capt_i    (seq_capt),
        .rel_req_i (bus_rel_req_i),
        .stb_i     (xfer_stb_i),
        .kind_o    (kind),
        .start_o   (seq_start)
    );

    odt_chan_out #(
        .DATA_W    (DATA_W),
        .NUM_CH    (NUM_CH),
        .DIRECT_CH (DIRECT_CH)
    ) i_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind_i     (kind),
        .data_i     (bus_data_i),
        .chan_req_o (chan_req_o),
        .req_word_o (req_word_o)
    );

endmodule

// File: rtl/odt_req_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for odt_req_ctrl, attached by bind. It tracks the cycles
// since each grant with its own counter, so that the release window is
// checked without a parameter-sized delay.
module odt_req_ctrl_chk #(
    parameter int NUM_CH    = 4,
    parameter int DIRECT_CH = 2,
    parameter int REL_DELAY = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rel_req_i,
    input logic              xfer_stb_i,
    input logic              bus_grant_o,
    input logic              bus_oe_o,
    input logic [NUM_CH-1:0] chan_req_o
);
    localparam int CW = $clog2(REL_DELAY + 2);

    logic          active_q;
    logic [CW-1:0] since_q;

    // Count cycles after the latest grant until its release cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            since_q  <= '0;
        end else if (bus_grant_o) begin
            active_q <= 1'b1;
            since_q  <= CW'(1);
        end else if (active_q) begin
            since_q <= since_q + 1'b1;
            if (since_q == CW'(REL_DELAY)) active_q <= 1'b0;
        end
    end

    assert_grant_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_grant_o |=> !bus_grant_o);

    assert_release_due_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && since_q == CW'(REL_DELAY)) |-> !bus_oe_o);

    assert_release_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_o |-> (active_q && since_q == CW'(REL_DELAY)));

    assert_reclaim_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_o |=> bus_oe_o);

    assert_capture_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_oe_o && xfer_stb_i) |=> (chan_req_o != '0));

    assert_no_strobe_no_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_oe_o && !xfer_stb_i) |=> (chan_req_o == '0));

    assert_direct_chan_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o && bus_rel_req_i && xfer_stb_i) |=> chan_req_o[DIRECT_CH]);

    assert_direct_no_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rel_req_i && xfer_stb_i) |=> !bus_grant_o);

    assert_busy_no_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> !bus_grant_o);

    assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_req_o));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rel_req_i && !xfer_stb_i) |=> (chan_req_o == '0));

endmodule

bind odt_req_ctrl odt_req_ctrl_chk #(
    .NUM_CH    (NUM_CH),
    .DIRECT_CH (DIRECT_CH),
    .REL_DELAY (REL_DELAY)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_rel_req_i (bus_rel_req_i),
    .xfer_stb_i    (xfer_stb_i),
    .bus_grant_o   (bus_grant_o),
    .bus_oe_o      (bus_oe_o),
    .chan_req_o    (chan_req_o)
);

// File: tb/test_odt_req_ctrl.sv
`timescale 1ns/1ps
// Bench: drives on the falling edge and advances a behavioural model at each
// rising edge. It compares every output 2 ns after the edge.
module test_odt_req_ctrl;
    localparam int REL = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        stb = 1'b0;
    logic [31:0] data = '0;
    logic        grant;
    logic        oe;
    logic [3:0]  chan;
    logic [31:0] word;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural model state
    int          m_cnt = -1;     // -1 idle, else cycles since grant
    int          m_last = 0;
    bit          m_last_v = 0;
    logic [31:0] m_word = '0;
    logic        e_grant = 1'b0;
    logic        e_oe = 1'b1;
    logic [3:0]  e_chan = '0;

    always #5 clk = ~clk;

    odt_req_ctrl i_odt_req_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_rel_req_i (req),
        .xfer_stb_i    (stb),
        .bus_data_i    (data),
        .bus_grant_o   (grant),
        .bus_oe_o      (oe),
        .chan_req_o    (chan),
        .req_word_o    (word)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string gtag, input string ctag);
        chk(grant === e_grant, gtag, "grant", 32'(grant), 32'(e_grant));
        chk(oe === e_oe, "R3", "bus_oe", 32'(oe), 32'(e_oe));
        chk(chan === e_chan, ctag, "chan_req", 32'(chan), 32'(e_chan));
        chk(word === m_word, "R4", "req_word", word, m_word);
    endtask

    // one clock with the given inputs; called just after a falling edge
    task automatic step(input logic r, input logic s, input logic [31:0] d);
        bit    rel;
        int    nxt;
        string ctag;
        string gtag;
        req = r; stb = s; data = d;
        @(posedge clk);
        rel = (m_cnt == REL);
        e_chan = '0;
        if (rel) begin
            if (s) begin
                e_chan = 4'b0001 << d[1:0];
                m_word = d; m_last = int'(d[1:0]); m_last_v = 1;
                ctag = "R4";
            end else ctag = "R5";
        end else if (s && r) begin
            e_chan = 4'b0100; m_last = 2; m_last_v = 1; ctag = "R8";
        end else if (s) begin
            if (m_last_v) begin e_chan = 4'b0001 << m_last; ctag = "R6"; end
            else ctag = "R7";
        end else ctag = "R10";
        if (m_cnt < 0) begin
            nxt = (r && !s) ? 0 : -1;
            gtag = (s && r) ? "R8" : "R2";
        end else begin
            nxt = rel ? -1 : m_cnt + 1;
            gtag = "R9";
        end
        m_cnt = nxt;
        e_grant = (nxt == 0);
        e_oe = (nxt != REL);
        #2;
        compare(gtag, ctag);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 32'h0);
    endtask

    // full format sequence: request, wait, strobe with word in release cycle
    task automatic fmt(input logic [31:0] d, input bit with_stb);
        step(1, 0, 32'h0);
        step(0, 0, 32'h0);
        step(0, 0, 32'h0);
        step(0, with_stb, d);
        step(0, 0, 32'h0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        compare("R1", "R1");
        rst_n = 1'b1;
        @(posedge clk); #2;
        compare("R1", "R1");
        @(negedge clk);

        // R7: repeat before anything remembered
        step(0, 1, 32'h0);
        idle(2);

        // R2 R3 R4: normal capture to channel 1
        fmt(32'hCAFE_0011 | 32'h1, 1);
        // R6: repeat of channel 1, word unchanged
        step(0, 1, 32'hFFFF_FFFF);
        idle(1);

        // R9: requests during grant and wait are ignored
        step(1, 0, 32'h0);
        step(1, 0, 32'h0);
        step(1, 0, 32'h0);
        step(1, 1, 32'h1234_5673);  // release cycle with req: captured, ch3
        step(0, 0, 32'h0);

        // R8: direct request, then repeat goes to channel 2
        step(1, 1, 32'h0000_0001);
        step(0, 1, 32'h0);
        idle(1);

        // R5: release cycle without strobe
        fmt(32'hDEAD_BEE0, 0);

        // R4: channels 2 and 0 via the word
        fmt(32'h0BAD_F00E, 1);
        fmt(32'h8000_0000, 1);
        step(0, 1, 32'h0);  // R6 repeat to channel 0

        // R9: request held high, back-to-back sequences
        for (int i = 0; i < 9; i++) step(1, 0, 32'h0);
        // strobe in grant cycle is a repeat
        step(0, 1, 32'h0);
        idle(3);

        // mixed pseudo-random traffic
        for (int i = 0; i < 2000; i++) begin
            logic r;
            logic s;
            r = ($urandom_range(0, 2) == 0);
            s = ($urandom_range(0, 3) == 0);
            step(r, s, $urandom);
        end
        idle(4);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule